// File: doc/BRIEF.md
# Error-Compensated Parallel Shift-Add Tree

This block forms the weighted sum Y = Σ y_j·2^-j of Q unsigned words, each P bits wide, in a single step. It does not shift and accumulate one word per cycle. Word j is aligned j columns to the right of word 0. Every column at or above the LSB of word 0 belongs to the main part and is added exactly. The columns below it form the truncation part. The block does not add that part. In its place it injects a small integer bias into the LSB of the main part.

The bias is built from two pieces. The first is the count of ones in the truncation column next to the main part, which is the one with the most weight. The second is a constant that depends only on Q. This constant stands in for the expected value of all the lower truncation columns, under the assumption that each of their bits is 1 half of the time. A parameter can remove the bias, which gives plain direct truncation for comparison. A second parameter selects either a registered output with a one-cycle valid pipeline or a purely combinational path. A typical use is the final accumulation stage of a distributed-arithmetic transform, where Q partial-product words arrive together.

Top module: `ecat_shift_add_tree`

## Requirements
- R1: While rst_n is low, and after its release until the first accepted input, out_valid is 0 and out_sum is 0 (registered variant).
- R2: out_sum (P+1 bits) equals Σ_{j=0..Q-1} floor(y_j / 2^j) + σ, where y_j is in_words[j*P +: P]. Word 0 carries output LSB weight 1.
- R3: The major count n is the number of ones among bit (j-1) of word j, for j = 1..Q-1. No other low-order bit affects out_sum.
- R4: For Q ≤ 3 in compensated mode, σ = floor((n+1)/2).
- R5: For Q = 4k or 4k+1 (k ≥ 1) in compensated mode, σ = k + floor(n/2).
- R6: For Q = 4k+2 or 4k+3 (k ≥ 1) in compensated mode, σ = k + floor((n+1)/2).
- R7: In direct-truncation mode σ = 0. out_sum·2^(Q-1) never exceeds the exact sum Σ y_j·2^(Q-1-j), and it falls short by less than Q·2^(Q-1).
- R8: With PIPE = 1, a word set accepted with in_valid at a rising edge produces out_valid = 1 and its out_sum right after that edge. With PIPE = 0, out_valid follows in_valid and out_sum follows in_words combinationally.
- R9: With PIPE = 1, a rising edge with in_valid low makes out_valid 0 and leaves out_sum unchanged.
- R10: In compensated mode, each result lies within Q output LSBs of the exact sum. Over random inputs, the total absolute error is below that of direct truncation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | The word set on in_words is valid this cycle |
| in_words | input | P*Q | Q words; word j at bits j*P +: P |
| out_valid | output | 1 | out_sum holds a result |
| out_sum | output | P+1 | Compensated (or truncated) weighted sum, LSB = LSB of word 0 |

## Verification
In the registered variants, the bench drives each word set at a falling edge. It then reads the result at the next falling edge, after the single register stage has captured it at the rising edge in between. The combinational variant has no register, so its result is due as soon as the inputs settle, and the bench reads it 1 ns after driving. In the idle check, the bench drops in_valid and changes the words. It then confirms at the following falling edge that the output register neither asserted valid nor picked up the new data.

// File: rtl/ecat_pkg.sv
// Package: shared types for the error-compensated shift-add tree.
// Assumes nothing beyond IEEE 1800-2017.
package ecat_pkg;

    // Selects how the truncation part is handled.
    typedef enum logic {
        TRUNC_COMPENSATED = 1'b0,
        TRUNC_DIRECT      = 1'b1
    } trunc_mode_e;

endpackage

// File: rtl/ecat_major_count.sv
// ecat_major_count: counts the ones in the truncation column adjacent to
// the main part, i.e. bit (j-1) of word j for j = 1..Q-1.
// Assumes Q >= 2 and P >= Q; CW is wide enough to hold Q-1.
module ecat_major_count #(
    parameter int P  = 12,
    parameter int Q  = 6,
    parameter int CW = 3
) (
    input  logic [P*Q-1:0] words,
    output logic [CW-1:0]  count
);

    // Bits outside the major column are intentionally not used here.
    logic unused_other_bits;
    assign unused_other_bits = ^words;

    // Population count over the major column.
    always_comb begin
        count = '0;
        for (int j = 1; j < Q; j++) begin
            count = count + CW'(words[j*P + j - 1]);
        end
    end

endmodule

// File: rtl/ecat_bias.sv
// ecat_bias: turns the major-column count into the integer bias that
// replaces the truncation part. The constant share stands for the
// expected value of the lower columns, each bit taken as 1 half the time.
// Assumes Q >= 2; the bias never exceeds Q-1, so CW bits are enough.
module ecat_bias
    import ecat_pkg::*;
#(
    parameter int          Q    = 6,
    parameter int          CW   = 3,
    parameter trunc_mode_e MODE = TRUNC_COMPENSATED
) (
    input  logic [CW-1:0] count,
    output logic [CW-1:0] sigma
);

    localparam int K = Q / 4;

    if (MODE == TRUNC_DIRECT) begin : g_direct
        // Direct truncation: no bias at all.
        logic unused_count;
        assign unused_count = ^count;
        assign sigma = '0;
    end else if (Q < 4) begin : g_small
        // Few words: round the half-weighted major column.
        always_comb sigma = CW'((int'(count) + 1) >> 1);
    end else if ((Q % 4) < 2) begin : g_low
        // Q = 4k or 4k+1: (k-1) + round(n/2 + 1/2).
        always_comb sigma = CW'(K + (int'(count) >> 1));
    end else begin : g_high
        // Q = 4k+2 or 4k+3: k + round(n/2).
        always_comb sigma = CW'(K + ((int'(count) + 1) >> 1));
    end

endmodule

// File: rtl/ecat_adder_tree.sv
// ecat_adder_tree: balanced binary tree summing N operands of W bits in
// one combinational step. Leaves are padded to a power of two with zeros.
// Assumes the caller sized W so that the sum cannot overflow.
module ecat_adder_tree #(
    parameter int N = 7,
    parameter int W = 13
) (
    input  logic [N*W-1:0] operands,
    output logic [W-1:0]   sum
);

    localparam int LEVELS = (N > 1) ? $clog2(N) : 0;
    localparam int LEAVES = 1 << LEVELS;

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int CNT = LEAVES >> l;
        logic [W-1:0] vals [CNT];
        if (l == 0) begin : g_leaf
            // Leaf level: operands, zero padding above N.
            for (genvar i = 0; i < CNT; i++) begin : g_in
                if (i < N) begin : g_real
                    assign vals[i] = operands[i*W +: W];
                end else begin : g_pad
                    assign vals[i] = '0;
                end
            end
        end else begin : g_node
            // Inner level: pairwise sums of the level below.
            for (genvar i = 0; i < CNT; i++) begin : g_add
                assign vals[i] = g_lvl[l-1].vals[2*i] + g_lvl[l-1].vals[2*i+1];
            end
        end
    end

    assign sum = g_lvl[LEVELS].vals[0];

endmodule

// File: rtl/ecat_shift_add_tree.sv
// ecat_shift_add_tree: parallel shift-add of Q P-bit words with an
// error-compensating bias in place of the truncated low columns.
// Word j is shifted right by j; the result keeps LSB weight of word 0
// and has one extra MSB for the carry. Assumes 2 <= Q <= P and P+Q < 63.
module ecat_shift_add_tree
    import ecat_pkg::*;
#(
    parameter int          P    = 12,
    parameter int          Q    = 6,
    parameter trunc_mode_e MODE = TRUNC_COMPENSATED,
    parameter bit          PIPE = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [P*Q-1:0] in_words,
    output logic           out_valid,
    output logic [P:0]     out_sum
);

    localparam int OW   = P + 1;
    localparam int CW   = $clog2(Q + 1);
    localparam int NOPS = Q + 1;

    logic [CW-1:0]      major_cnt;
    logic [CW-1:0]      bias;
    logic [NOPS*OW-1:0] operands;
    logic [OW-1:0]      comb_sum;

    // Low truncation bits are dropped on purpose.
    logic unused_minor_bits;
    assign unused_minor_bits = ^in_words;

    ecat_major_count #(.P(P), .Q(Q), .CW(CW)) u_major (
        .words (in_words),
        .count (major_cnt)
    );

    ecat_bias #(.Q(Q), .CW(CW), .MODE(MODE)) u_bias (
        .count (major_cnt),
        .sigma (bias)
    );

    // Main-part operands: each word's columns at or above output LSB.
    for (genvar j = 0; j < Q; j++) begin : g_opnd
        assign operands[j*OW +: OW] = OW'(in_words[j*P + j +: P - j]);
    end
    assign operands[Q*OW +: OW] = OW'(bias);

    ecat_adder_tree #(.N(NOPS), .W(OW)) u_tree (
        .operands (operands),
        .sum      (comb_sum)
    );

    if (PIPE) begin : g_reg
        // Output register: capture on valid, clear on reset, hold otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                out_sum   <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) out_sum <= comb_sum;
            end
        end
    end else begin : g_comb
        // Combinational variant: the clock and reset are not needed.
        logic unused_clk_rst;
        assign unused_clk_rst = clk ^ rst_n;
        assign out_valid = in_valid;
        assign out_sum   = comb_sum;
    end

endmodule

// File: rtl/ecat_checks.sv
// ecat_checks: assertion checker for ecat_shift_add_tree, bound below.
// Compares the result with the exact weighted sum scaled by 2^(Q-1).
module ecat_checks
    import ecat_pkg::*;
#(
    parameter int          P    = 12,
    parameter int          Q    = 6,
    parameter trunc_mode_e MODE = TRUNC_COMPENSATED,
    parameter bit          PIPE = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [P*Q-1:0] in_words,
    input logic           out_valid,
    input logic [P:0]     out_sum
);

    localparam longint BOUND = longint'(Q) <<< (Q - 1);

    longint exact_now;
    longint scaled;

    // Exact sum of the present inputs, and the result on the same scale.
    always_comb begin
        exact_now = 0;
        for (int j = 0; j < Q; j++) begin
            exact_now = exact_now + (longint'(in_words[j*P +: P]) <<< (Q - 1 - j));
        end
        scaled = longint'(out_sum) <<< (Q - 1);
    end

    if (PIPE) begin : g_seq
        a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (!out_valid && out_sum == '0))
            else $error("a_r1_reset_clear");
        a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid)
            else $error("a_r8_valid_latency");
        a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && $stable(out_sum)))
            else $error("a_r9_idle_hold");
        if (MODE == TRUNC_COMPENSATED) begin : g_cmp
            a_r10_error_bound: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (((scaled >= $past(exact_now)) ? (scaled - $past(exact_now))
                                 : ($past(exact_now) - scaled)) <= BOUND))
                else $error("a_r10_error_bound");
        end else begin : g_dir
            a_r7_below_exact: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (scaled <= $past(exact_now) && ($past(exact_now) - scaled) < BOUND))
                else $error("a_r7_below_exact");
        end
    end else begin : g_cmb
        a_r8_comb_valid: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid)
            else $error("a_r8_comb_valid");
        if (MODE == TRUNC_COMPENSATED) begin : g_cmp
            a_r10_error_bound_comb: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |-> (((scaled >= exact_now) ? (scaled - exact_now)
                                : (exact_now - scaled)) <= BOUND))
                else $error("a_r10_error_bound_comb");
        end
    end

endmodule

bind ecat_shift_add_tree ecat_checks #(.P(P), .Q(Q), .MODE(MODE), .PIPE(PIPE)) u_checks (.*);

// File: tb/ecat_shift_add_tree_tb.sv
`timescale 1ns/1ps
module ecat_shift_add_tree_tb;
    import ecat_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [71:0] in6 = '0;
    logic [31:0] in4 = '0;
    logic [23:0] in3 = '0;
    logic        v_dut, v_trunc, v_q4, v_q3;
    logic [12:0] s_dut, s_trunc;
    logic [8:0]  s_q4, s_q3;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    longint err_comp = 0;
    longint err_trunc = 0;

    always #2.5 clk = ~clk;

    ecat_shift_add_tree #(.P(12), .Q(6), .MODE(TRUNC_COMPENSATED), .PIPE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_words(in6),
        .out_valid(v_dut), .out_sum(s_dut));
    ecat_shift_add_tree #(.P(12), .Q(6), .MODE(TRUNC_DIRECT), .PIPE(1'b1)) u_trunc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_words(in6),
        .out_valid(v_trunc), .out_sum(s_trunc));
    ecat_shift_add_tree #(.P(8), .Q(4), .MODE(TRUNC_COMPENSATED), .PIPE(1'b1)) u_q4 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_words(in4),
        .out_valid(v_q4), .out_sum(s_q4));
    ecat_shift_add_tree #(.P(8), .Q(3), .MODE(TRUNC_COMPENSATED), .PIPE(1'b0)) u_q3 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_words(in3),
        .out_valid(v_q3), .out_sum(s_q3));

    // Golden bias model written from the requirements.
    function automatic longint model(input int q, input bit direct, input longint w[8]);
        longint main_part = 0;
        longint n = 0;
        longint sig;
        longint k = q / 4;
        for (int j = 0; j < q; j++) main_part += w[j] >> j;
        for (int j = 1; j < q; j++) n += (w[j] >> (j - 1)) & 1;
        if (direct)            sig = 0;
        else if (q < 4)        sig = (n + 1) / 2;
        else if ((q % 4) < 2)  sig = k + n / 2;
        else                   sig = k + (n + 1) / 2;
        return main_part + sig;
    endfunction

    // Exact weighted sum scaled by 2^(q-1).
    function automatic longint exact(input int q, input longint w[8]);
        longint s = 0;
        for (int j = 0; j < q; j++) s += w[j] << (q - 1 - j);
        return s;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Drive one word set at a falling edge, check all variants.
    task automatic run_vec(input longint a[8], input longint b[8], input longint c[8]);
        longint e6, e6t, e4, e3, d;
        for (int j = 0; j < 6; j++) in6[j*12 +: 12] = a[j][11:0];
        for (int j = 0; j < 4; j++) in4[j*8 +: 8] = b[j][7:0];
        for (int j = 0; j < 3; j++) in3[j*8 +: 8] = c[j][7:0];
        in_valid = 1'b1;
        e6  = model(6, 1'b0, a);
        e6t = model(6, 1'b1, a);
        e4  = model(4, 1'b0, b);
        e3  = model(3, 1'b0, c);
        #1;
        check(v_q3 == 1'b1 && longint'(s_q3) == e3, "R4 R8 q3 combinational", longint'(s_q3), e3);
        @(negedge clk);
        check(v_dut == 1'b1, "R8 q6 valid one cycle later", longint'(v_dut), 1);
        check(longint'(s_dut) == e6, "R2 R3 R6 q6 compensated", longint'(s_dut), e6);
        check(longint'(s_trunc) == e6t, "R7 q6 direct truncation", longint'(s_trunc), e6t);
        check(longint'(s_q4) == e4, "R5 q4 compensated", longint'(s_q4), e4);
        d = (longint'(s_dut) << 5) - exact(6, a);
        if (d < 0) d = -d;
        check(d <= 6 * 32, "R10 per-result error bound", d, 6 * 32);
        err_comp += d;
        d = exact(6, a) - (longint'(s_trunc) << 5);
        check(d >= 0 && d < 6 * 32, "R7 truncation below exact", d, 0);
        err_trunc += d;
    endtask

    initial begin : main
        longint a[8], b[8], c[8];
        logic [12:0] held;
        void'($urandom(32'd20240611));
        // R1: reset state.
        repeat (3) @(negedge clk);
        check(v_dut == 1'b0 && s_dut == '0, "R1 in reset", longint'(s_dut), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(v_dut == 1'b0 && s_dut == '0, "R1 after release", longint'(s_dut), 0);

        // Directed corners.
        for (int j = 0; j < 8; j++) begin a[j] = 0; b[j] = 0; c[j] = 0; end
        run_vec(a, b, c);                                  // all zero
        for (int j = 0; j < 8; j++) begin a[j] = 'hFFF; b[j] = 'hFF; c[j] = 'hFF; end
        run_vec(a, b, c);                                  // all ones
        for (int j = 0; j < 8; j++) begin
            a[j] = (j == 0) ? 0 : (longint'(1) << (j - 1));
            b[j] = a[j]; c[j] = a[j];
        end
        run_vec(a, b, c);                                  // R3: major column only
        for (int j = 0; j < 8; j++) begin
            a[j] = (j < 2) ? 0 : (longint'(1) << (j - 1)) - 1;
            b[j] = a[j]; c[j] = a[j];
        end
        run_vec(a, b, c);                                  // R3: minor bits only
        for (int j = 0; j < 8; j++) begin a[j] = 'hAAA >> (j % 2); b[j] = 'h55; c[j] = 'hAA; end
        run_vec(a, b, c);                                  // alternating

        // Random vectors, back to back.
        for (int t = 0; t < 2000; t++) begin
            for (int j = 0; j < 8; j++) begin
                a[j] = longint'($urandom) & 'hFFF;
                b[j] = longint'($urandom) & 'hFF;
                c[j] = longint'($urandom) & 'hFF;
            end
            run_vec(a, b, c);
        end

        // R10: average error of compensation beats direct truncation.
        check(err_comp < err_trunc, "R10 compensated error below truncation", err_comp, err_trunc);

        // R9: idle input leaves the registered result alone.
        held = s_dut;
        in_valid = 1'b0;
        in6 = ~in6;
        @(negedge clk);
        check(v_dut == 1'b0, "R9 idle valid low", longint'(v_dut), 0);
        check(s_dut == held, "R9 idle result held", longint'(s_dut), longint'(held));

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R8 actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule